// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Sequencer

This block sits between the phase modulator of a multiphase PWM converter and the gate drivers. It receives a synchronous overcurrent flag from an external comparator. While the power stage runs normally, the modulator's per-phase PWM requests pass through unchanged, and every phase output enable is high. When the flag rises, all output enables drop in the same cycle. The drivers read a released phase as a command to turn off both switches.

After a fault the sequencer sits in a tri-stated wait state for a fixed number of phase-clock cycles. It then performs a soft-start, which ramps a reference code from zero to full scale. If the ramp reaches full scale with no further overcurrent, the converter returns to normal running. If the flag fires during the ramp, the attempt has failed and the wait starts over. The wait-and-retry loop repeats for as long as the block stays enabled. Dropping enable releases all phases and clears the retry history. Raising enable again starts a fresh soft-start.

The states are IDLE (disabled), SOFT (ramping), RUN (normal) and WAIT (hiccup hold-off). The transitions are:
- IDLE→SOFT on enable.
- SOFT→RUN when the ramp reaches full scale.
- SOFT→WAIT on overcurrent.
- RUN→WAIT on overcurrent.
- WAIT→SOFT when the hold-off count expires.
- Any state→IDLE when enable is low.

Top module: `hiccup_ctrl`

## Requirements
- R1: While `en` is low (including just after reset), `pwm_oe` and `pwm_out` are all zero, `ss_code` is 0, and `run_ok`, `hiccup_act` and `retry_cnt` are 0.
- R2: In SOFT, every `pwm_oe` bit is 1 and `pwm_out` equals `pwm_req`. In the k-th SOFT cycle (k starting at 0), `ss_code` equals k / STEP_CYC, so the code rises one step every STEP_CYC cycles.
- R3: A soft-start with no overcurrent lasts (2^CODE_W − 1)·STEP_CYC + 1 cycles and is followed by RUN. In RUN, `run_ok` is 1, `ss_code` is all ones, every `pwm_oe` bit is 1, and `pwm_out` equals `pwm_req`.
- R4: In any cycle where `oc_flag` is high, every `pwm_oe` and `pwm_out` bit is 0 in that same cycle. An overcurrent seen in RUN moves the block to WAIT on the next clock.
- R5: WAIT lasts exactly WAIT_CYC cycles, with all `pwm_oe` bits 0 and `ss_code` 0, and is then followed by SOFT.
- R6: `oc_flag` pulses during WAIT do not change the length of WAIT.
- R7: An overcurrent during SOFT sends the block to WAIT on the next clock. `ss_code` is 0 from the first WAIT cycle, and a full WAIT_CYC-cycle wait follows.
- R8: `hiccup_act` is 1 in WAIT and in a SOFT that follows a fault. It is 0 in a SOFT that follows enable, and 0 in RUN.
- R9: `retry_cnt` rises by one at each WAIT→SOFT transition and saturates at all ones. It never falls while `en` stays high.
- R10: When `en` goes low, `pwm_oe` drops in that same cycle. From the next cycle the block is in IDLE with `retry_cnt` and `hiccup_act` cleared. Raising `en` again starts a soft-start with `hiccup_act` low.
- R11: A successful soft-start after a fault gives RUN with `hiccup_act` low and `retry_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable |
| oc_flag | input | 1 | Synchronous overcurrent comparator flag |
| pwm_req | input | NPH | Per-phase PWM requests from the modulator |
| pwm_out | output | NPH | Gated per-phase PWM level |
| pwm_oe | output | NPH | Per-phase output enable (0 = high impedance) |
| ss_code | output | CODE_W | Soft-start reference ramp code |
| run_ok | output | 1 | Normal operation reached |
| hiccup_act | output | 1 | Hold-off wait or post-fault soft-start in progress |
| retry_cnt | output | RETRY_W | Saturating count of retry attempts |

## Verification
The bench builds the block with WAIT_CYC = 20, CODE_W = 3, STEP_CYC = 2 and RETRY_W = 2, keeping the four phases. With these values every wait and ramp can be counted cycle by cycle, and a full soft-start takes 15 cycles. A two-bit retry count saturates after three retries, so a held overcurrent drives it into saturation quickly. The default 2048-cycle wait and 8-bit ramp differ from the bench values only in their counter widths.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2,
        ST_WAIT = 2'd3
    } hic_state_t;
endpackage

// File: rtl/hiccup_wait_timer.sv
module hiccup_wait_timer #(
    parameter int WAIT_CYC = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int WW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [WW-1:0] LAST = WW'(WAIT_CYC - 1);

    logic [WW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = active && (cnt == LAST);
endmodule

// File: rtl/hiccup_ramp.sv
module hiccup_ramp #(
    parameter int CODE_W   = 8,
    parameter int STEP_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step_en,
    output logic [CODE_W-1:0] code,
    output logic              full
);
    localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [SW-1:0] PRE_LAST = SW'(STEP_CYC - 1);

    logic [SW-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre  <= '0;
            code <= '0;
        end else if (clear) begin
            pre  <= '0;
            code <= '0;
        end else if (step_en && !full) begin
            if (pre == PRE_LAST) begin
                pre  <= '0;
                code <= code + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign full = &code;
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
    import hiccup_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               oc_flag,
    input  logic               ramp_full,
    input  logic               wait_done,
    output hic_state_t         st,
    output hic_state_t         nxt,
    output logic               post_fault,
    output logic [RETRY_W-1:0] retry_cnt
);
    always_comb begin
        nxt = st;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_SOFT;
                ST_SOFT: nxt = oc_flag ? ST_WAIT : (ramp_full ? ST_RUN : ST_SOFT);
                ST_RUN:  nxt = oc_flag ? ST_WAIT : ST_RUN;
                ST_WAIT: nxt = wait_done ? ST_SOFT : ST_WAIT;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_fault <= 1'b0;
            retry_cnt  <= '0;
        end else begin
            if (nxt == ST_WAIT)
                post_fault <= 1'b1;
            else if (nxt == ST_RUN || nxt == ST_IDLE)
                post_fault <= 1'b0;

            if (!en)
                retry_cnt <= '0;
            else if (st == ST_WAIT && nxt == ST_SOFT && !(&retry_cnt))
                retry_cnt <= retry_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hiccup_phase_gate.sv
module hiccup_phase_gate #(
    parameter int NPH = 4
) (
    input  logic           drive,
    input  logic [NPH-1:0] req,
    output logic [NPH-1:0] out,
    output logic [NPH-1:0] oe
);
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign oe[p]  = drive;
        assign out[p] = drive & req[p];
    end
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
    import hiccup_pkg::*;
#(
    parameter int NPH      = 4,
    parameter int WAIT_CYC = 2048,
    parameter int CODE_W   = 8,
    parameter int STEP_CYC = 16,
    parameter int RETRY_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               oc_flag,
    input  logic [NPH-1:0]     pwm_req,
    output logic [NPH-1:0]     pwm_out,
    output logic [NPH-1:0]     pwm_oe,
    output logic [CODE_W-1:0]  ss_code,
    output logic               run_ok,
    output logic               hiccup_act,
    output logic [RETRY_W-1:0] retry_cnt
);
    hic_state_t st, nxt;
    logic post_fault, ramp_full, wait_done, drive;

    hiccup_fsm #(.RETRY_W(RETRY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_flag(oc_flag),
        .ramp_full(ramp_full), .wait_done(wait_done),
        .st(st), .nxt(nxt), .post_fault(post_fault), .retry_cnt(retry_cnt)
    );

    hiccup_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk(clk), .rst_n(rst_n), .active(st == ST_WAIT), .done(wait_done)
    );

    hiccup_ramp #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk(clk), .rst_n(rst_n),
        .clear(nxt == ST_WAIT || nxt == ST_IDLE),
        .step_en(st == ST_SOFT),
        .code(ss_code), .full(ramp_full)
    );

    always_comb begin
        drive      = 1'b0;
        run_ok     = 1'b0;
        hiccup_act = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_SOFT: begin
                drive      = en && !oc_flag;
                hiccup_act = post_fault;
            end
            ST_RUN: begin
                drive  = en && !oc_flag;
                run_ok = 1'b1;
            end
            ST_WAIT: hiccup_act = 1'b1;
            default: ;
        endcase
    end

    hiccup_phase_gate #(.NPH(NPH)) u_gate (
        .drive(drive), .req(pwm_req), .out(pwm_out), .oe(pwm_oe)
    );
endmodule

// File: rtl/hiccup_ctrl_chk.sv
module hiccup_ctrl_chk
    import hiccup_pkg::*;
#(
    parameter int NPH      = 4,
    parameter int WAIT_CYC = 2048,
    parameter int CODE_W   = 8,
    parameter int RETRY_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               oc_flag,
    input logic [NPH-1:0]     pwm_oe,
    input logic [CODE_W-1:0]  ss_code,
    input logic               run_ok,
    input logic               hiccup_act,
    input logic [RETRY_W-1:0] retry_cnt,
    input hic_state_t         st
);
    int wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wcnt <= 0;
        else if (st == ST_WAIT)
            wcnt <= wcnt + 1;
        else
            wcnt <= 0;
    end

    // R4
    oc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |-> (pwm_oe == '0));

    // R5
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (wcnt < WAIT_CYC));

    // R5
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && wcnt == WAIT_CYC - 1 && en) |=> (st == ST_SOFT));

    // R8
    wait_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> hiccup_act);

    // R3
    run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok |-> (&ss_code) && !hiccup_act);

    // R9
    retry_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> (retry_cnt >= $past(retry_cnt)));

    // R10
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_IDLE) && (retry_cnt == '0));
endmodule

bind hiccup_ctrl hiccup_ctrl_chk #(
    .NPH(NPH), .WAIT_CYC(WAIT_CYC), .CODE_W(CODE_W), .RETRY_W(RETRY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .oc_flag(oc_flag), .pwm_oe(pwm_oe),
    .ss_code(ss_code), .run_ok(run_ok), .hiccup_act(hiccup_act),
    .retry_cnt(retry_cnt), .st(st)
);

// File: tb/test_hiccup_ctrl.sv
module test_hiccup_ctrl;
    localparam int NPH      = 4;
    localparam int WAIT_CYC = 20;
    localparam int CODE_W   = 3;
    localparam int STEP_CYC = 2;
    localparam int RETRY_W  = 2;
    localparam int SOFT_LEN = ((1 << CODE_W) - 1) * STEP_CYC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic oc_flag = 1'b0;
    logic [NPH-1:0] pwm_req = '0;
    logic [NPH-1:0] pwm_out, pwm_oe;
    logic [CODE_W-1:0] ss_code;
    logic run_ok, hiccup_act;
    logic [RETRY_W-1:0] retry_cnt;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    hiccup_ctrl #(
        .NPH(NPH), .WAIT_CYC(WAIT_CYC), .CODE_W(CODE_W),
        .STEP_CYC(STEP_CYC), .RETRY_W(RETRY_W)
    ) i_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_flag(oc_flag),
        .pwm_req(pwm_req), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
        .ss_code(ss_code), .run_ok(run_ok), .hiccup_act(hiccup_act),
        .retry_cnt(retry_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_wait(output int n, input int pulse_at);
        int errs = 0;
        n = 0;
        while (pwm_oe == '0 && hiccup_act && n < 500) begin
            if (ss_code != '0) errs++;
            oc_flag = (n == pulse_at);
            @(negedge clk);
            n++;
        end
        oc_flag = 1'b0;
        chk(errs == 0, "R5 code zero in wait", errs, 0);
    endtask

    task automatic run_soft(output int n, input logic exp_hic);
        int errs = 0;
        n = 0;
        while (!run_ok && n < 500) begin
            if (pwm_oe != '1 || pwm_out != pwm_req) errs++;
            if (ss_code != CODE_W'(n / STEP_CYC)) errs++;
            if (hiccup_act != exp_hic) errs++;
            @(negedge clk);
            n++;
        end
        chk(errs == 0, "R2 R8 soft-start ramp and flags", errs, 0);
    endtask

    task automatic t_reset();
        chk(pwm_oe == '0 && pwm_out == '0, "R1 outputs released", int'(pwm_oe), 0);
        chk(ss_code == '0 && !run_ok && !hiccup_act && retry_cnt == '0,
            "R1 status clear", int'(ss_code), 0);
    endtask

    task automatic t_fresh_start();
        int n;
        pwm_req = 4'b1010;
        en = 1'b1;
        @(negedge clk);
        run_soft(n, 1'b0);
        chk(n == SOFT_LEN, "R3 soft-start length", n, SOFT_LEN);
        chk(run_ok && pwm_oe == '1 && pwm_out == 4'b1010, "R3 run passthrough", int'(pwm_out), 10);
        pwm_req = 4'b0101;
        #1;
        chk(pwm_out == 4'b0101, "R3 run follows request", int'(pwm_out), 5);
        chk(!hiccup_act, "R8 no hiccup in run", int'(hiccup_act), 0);
    endtask

    task automatic t_oc_run();
        int n;
        oc_flag = 1'b1;
        #1;
        chk(pwm_oe == '0 && pwm_out == '0, "R4 same-cycle release", int'(pwm_oe), 0);
        @(negedge clk);
        oc_flag = 1'b0;
        chk(hiccup_act && !run_ok, "R4 enters wait", int'(hiccup_act), 1);
        count_wait(n, 5);
        chk(n == WAIT_CYC, "R6 R5 wait length with pulse", n, WAIT_CYC);
        chk(retry_cnt == 2'd1, "R9 retry after first wait", int'(retry_cnt), 1);
        run_soft(n, 1'b1);
        chk(n == SOFT_LEN, "R11 retry soft-start completes", n, SOFT_LEN);
        chk(run_ok && !hiccup_act && retry_cnt == 2'd1, "R11 run after retry", int'(retry_cnt), 1);
    endtask

    task automatic t_oc_soft();
        int n;
        oc_flag = 1'b1;
        @(negedge clk);
        oc_flag = 1'b0;
        count_wait(n, -1);
        chk(n == WAIT_CYC, "R5 wait length", n, WAIT_CYC);
        chk(retry_cnt == 2'd2, "R9 retry second", int'(retry_cnt), 2);
        repeat (3) @(negedge clk);
        chk(ss_code == 3'd1, "R2 mid-ramp code", int'(ss_code), 1);
        oc_flag = 1'b1;
        #1;
        chk(pwm_oe == '0, "R4 release during soft", int'(pwm_oe), 0);
        @(negedge clk);
        oc_flag = 1'b0;
        chk(ss_code == '0 && hiccup_act && pwm_oe == '0, "R7 back to wait", int'(ss_code), 0);
        count_wait(n, -1);
        chk(n == WAIT_CYC, "R7 full wait after failed soft", n, WAIT_CYC);
        chk(retry_cnt == 2'd3, "R9 retry third", int'(retry_cnt), 3);
        run_soft(n, 1'b1);
        chk(run_ok, "R11 run after failed attempt", int'(run_ok), 1);
    endtask

    task automatic t_disable();
        int n;
        en = 1'b0;
        #1;
        chk(pwm_oe == '0, "R10 immediate release", int'(pwm_oe), 0);
        @(negedge clk);
        chk(!run_ok && !hiccup_act && retry_cnt == '0 && ss_code == '0,
            "R10 idle cleared", int'(retry_cnt), 0);
        en = 1'b1;
        @(negedge clk);
        run_soft(n, 1'b0);
        chk(n == SOFT_LEN && run_ok, "R10 fresh soft-start", n, SOFT_LEN);
    endtask

    task automatic t_saturate();
        int n;
        int errs = 0;
        oc_flag = 1'b1;
        repeat (8 * (WAIT_CYC + 1)) begin
            @(negedge clk);
            if (pwm_oe != '0) errs++;
        end
        chk(errs == 0, "R4 held fault keeps released", errs, 0);
        chk(retry_cnt == 2'd3, "R9 saturation", int'(retry_cnt), 3);
        oc_flag = 1'b0;
        n = 0;
        while (!run_ok && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(run_ok && retry_cnt == 2'd3 && !hiccup_act, "R11 recovery keeps count", int'(retry_cnt), 3);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_fresh_start();
                t_oc_run();
                t_oc_soft();
                t_disable();
                t_saturate();
            end
            begin
                repeat (20000) @(negedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule